// File: doc/BRIEF.md
# Multi-Target Mailbox Send Inbox

This block is the sending half of an inter-processor mailbox. Software stages a 64-bit message as two 32-bit words and picks a destination core (0 to 7). It then writes a commit bit, and the block appends the message to a small queue that belongs to that destination. Each destination core reads its own queue through a head-of-queue view and removes the head entry with a per-target pop strobe.

All per-target state is gathered into one status word. It shows which queues still hold unread messages, which targets lost a message because their queue was full, and which targets have taken a message. The lost-message and taken-message flags stay set until software writes ones to the matching bit positions of a clear register. A single interrupt line reports unmasked lost-message and taken-message events. Its pending bit is cleared by writing one to it.

The register port is a plain single-cycle port. A write takes effect at the clock edge where the write enable is high. Read data is a combinational function of the address and the current register state.

Top module: `mbox_inbox`

## Requirements
- R1: After reset the status word (offset 0x14) and the interrupt-pending register (offset 0x18) read 0, the mask register (offset 0x1C) reads 3'b111, every queue is empty and `irq` is low.
- R2: Writes to offset 0x04 (low word) and offset 0x08 (high word) are read back unchanged. A write to offset 0x00 stores the destination index from data bits [2:0], and a read returns that index zero-extended.
- R3: A write to offset 0x0C with data bit 0 set appends {high word, low word} to the queue of the stored destination. Messages to one destination leave in the order they were committed. A write to 0x0C with bit 0 clear changes nothing.
- R4: Status bits [7:0] hold the busy flags: bit n is 1 while the queue of target n is not empty. These bits match `rxNotEmpty`.
- R5: Each queue holds 4 messages. A commit to a destination whose queue is full at that edge discards the message, leaves the queue unchanged and sets status bit 8+n. A pop by that target in the same cycle does not make room for the commit.
- R6: A pop strobe for target n whose queue is not empty removes the head entry and sets status bit 16+n. A pop on an empty queue has no effect.
- R7: A write to offset 0x10 clears every taken-message flag whose data bit 16+n is 1 and every lost-message flag whose data bit 8+n is 1. A flag set by an event in the same cycle stays set.
- R8: Pending bit 0 at offset 0x18 sets on a lost-message event while mask bit 1 is 0, or on a taken-message event while mask bit 2 is 0. Writing 1 to bit 0 clears it. An event in the same cycle wins over the clear.
- R9: The mask register at offset 0x1C holds bits [2:0] as written. `irq` equals the pending bit AND NOT mask bit 0.
- R10: `rxData` shows the head message of the queue chosen by `rxSel`, whenever that queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| popReq | input | 8 | Per-target pop strobe from the receiving cores |
| rxSel | input | 3 | Target whose queue head is shown on rxData |
| rxData | output | 64 | Head message of the selected queue |
| rxNotEmpty | output | 8 | Per-target queue-not-empty flags |
| irq | output | 1 | Interrupt to the sending core |

## Verification
Every write, commit and pop is registered once at the edge where it is presented. Its effect on queue contents, flags, pending bit, `irq`, `rxNotEmpty` and `rxData` is therefore due right after that same edge. Register reads are combinational and are due in the same cycle as the address. The bench drives each stimulus for exactly one edge and advances a behavioural queue model at that edge. It compares `irq`, `rxNotEmpty` and the selected head 1 ns after the edge, and performs register reads in the quiet part of the cycle that follows.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W   = 5;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 8;
  localparam int MAX_ID_W = 3;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFF_TGT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_LO   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_HI   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_GO   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_PEND = 5'h18;
  localparam logic [ADDR_W-1:0] OFF_MASK = 5'h1C;

  // field positions inside the status word
  localparam int POS_BUSY = 0;
  localparam int POS_LOST = 8;
  localparam int POS_TAKE = 16;

  // mask bits
  localparam int MSK_LINE = 0;
  localparam int MSK_LOST = 1;
  localparam int MSK_TAKE = 2;
  localparam int MSK_W    = 3;

  typedef struct packed {
    logic                commit;
    logic [MAX_ID_W-1:0] tgt;
  } dpStrobe_t;
endpackage

// File: rtl/mbox_tgt_fifo.sv
module mbox_tgt_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         notEmpty,
  output logic         popAck
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign notEmpty = (count != '0);
  assign popAck   = pop & notEmpty;
  assign doPush   = push & ~full;
  assign dout     = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (popAck) rdPtr <= nextPtr(rdPtr);
      case ({doPush, popAck})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int DEPTH   = 4,
  parameter int ID_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [2*WORD_W-1:0] msgWord,
  input  logic [NUM_TGT-1:0]  popReq,
  input  logic [ID_W-1:0]     rxSel,
  output logic [NUM_TGT-1:0]  fullVec,
  output logic [NUM_TGT-1:0]  nonEmpty,
  output logic [NUM_TGT-1:0]  popAck,
  output logic [2*WORD_W-1:0] rxData
);
  localparam int MSG_W = 2 * WORD_W;

  logic [MSG_W-1:0] headArr [NUM_TGT];

  for (genvar gT = 0; gT < NUM_TGT; gT++) begin : g_tgt
    logic pushHit;
    assign pushHit = strobe.commit && (strobe.tgt == MAX_ID_W'(gT));

    mbox_tgt_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushHit),
      .pop      (popReq[gT]),
      .din      (msgWord),
      .dout     (headArr[gT]),
      .full     (fullVec[gT]),
      .notEmpty (nonEmpty[gT]),
      .popAck   (popAck[gT])
    );
  end

  assign rxData = headArr[rxSel];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int ID_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWrData,
  output logic [WORD_W-1:0]   busRdData,
  input  logic [NUM_TGT-1:0]  fullVec,
  input  logic [NUM_TGT-1:0]  nonEmpty,
  input  logic [NUM_TGT-1:0]  popAck,
  output dpStrobe_t           strobe,
  output logic [2*WORD_W-1:0] msgWord,
  output logic                irq
);
  logic [ID_W-1:0]    idReg;
  logic [WORD_W-1:0]  loReg, hiReg;
  logic [NUM_TGT-1:0] lostFlags, takeFlags;
  logic [NUM_TGT-1:0] dropVec, lostClr, takeClr;
  logic [MSK_W-1:0]   maskReg;
  logic               pend, pendSet, pendClr;
  logic               wrTgt, wrLo, wrHi, wrGo, wrClr, wrPend, wrMask, commitHit;

  // write decode
  assign wrTgt     = busWrEn && (busAddr == OFF_TGT);
  assign wrLo      = busWrEn && (busAddr == OFF_LO);
  assign wrHi      = busWrEn && (busAddr == OFF_HI);
  assign wrGo      = busWrEn && (busAddr == OFF_GO);
  assign wrClr     = busWrEn && (busAddr == OFF_CLR);
  assign wrPend    = busWrEn && (busAddr == OFF_PEND);
  assign wrMask    = busWrEn && (busAddr == OFF_MASK);
  assign commitHit = wrGo && busWrData[0];

  assign strobe.commit = commitHit;
  assign strobe.tgt    = MAX_ID_W'(idReg);
  assign msgWord       = {hiReg, loReg};

  // a commit into a full queue is discarded and marked as lost
  always_comb begin
    for (int t = 0; t < NUM_TGT; t++) begin
      dropVec[t] = commitHit && (idReg == ID_W'(t)) && fullVec[t];
    end
  end

  assign lostClr = wrClr ? busWrData[POS_LOST +: NUM_TGT] : '0;
  assign takeClr = wrClr ? busWrData[POS_TAKE +: NUM_TGT] : '0;
  assign pendSet = ((|dropVec) && !maskReg[MSK_LOST]) ||
                   ((|popAck)  && !maskReg[MSK_TAKE]);
  assign pendClr = wrPend && busWrData[0];

  // staging registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg <= '0;
      loReg <= '0;
      hiReg <= '0;
    end else begin
      if (wrTgt) idReg <= busWrData[ID_W-1:0];
      if (wrLo)  loReg <= busWrData;
      if (wrHi)  hiReg <= busWrData;
    end
  end

  // sticky flags, pending bit, mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lostFlags <= '0;
      takeFlags <= '0;
      pend      <= 1'b0;
      maskReg   <= '1;
    end else begin
      lostFlags <= (lostFlags & ~lostClr) | dropVec;
      takeFlags <= (takeFlags & ~takeClr) | popAck;
      pend      <= pendSet | (pend & ~pendClr);
      if (wrMask) maskReg <= busWrData[MSK_W-1:0];
    end
  end

  assign irq = pend & ~maskReg[MSK_LINE];

  // read mux
  logic [FIELD_W-1:0] busyF, lostF, takeF;
  logic [WORD_W-1:0]  statWord;

  always_comb begin
    busyF = '0;
    lostF = '0;
    takeF = '0;
    busyF[NUM_TGT-1:0] = nonEmpty;
    lostF[NUM_TGT-1:0] = lostFlags;
    takeF[NUM_TGT-1:0] = takeFlags;
    statWord = '0;
    statWord[POS_BUSY +: FIELD_W] = busyF;
    statWord[POS_LOST +: FIELD_W] = lostF;
    statWord[POS_TAKE +: FIELD_W] = takeF;
  end

  always_comb begin
    case (busAddr)
      OFF_TGT:  busRdData = WORD_W'(idReg);
      OFF_LO:   busRdData = loReg;
      OFF_HI:   busRdData = hiReg;
      OFF_STAT: busRdData = statWord;
      OFF_PEND: busRdData = WORD_W'(pend);
      OFF_MASK: busRdData = WORD_W'(maskReg);
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/mbox_inbox.sv
module mbox_inbox
  import mbox_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int DEPTH   = 4,
  parameter int ID_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWrData,
  output logic [WORD_W-1:0]   busRdData,
  input  logic [NUM_TGT-1:0]  popReq,
  input  logic [ID_W-1:0]     rxSel,
  output logic [2*WORD_W-1:0] rxData,
  output logic [NUM_TGT-1:0]  rxNotEmpty,
  output logic                irq
);
  dpStrobe_t           strobe;
  logic [2*WORD_W-1:0] msgWord;
  logic [NUM_TGT-1:0]  fullVec, popAck;

  mbox_ctrl #(.NUM_TGT(NUM_TGT), .ID_W(ID_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .fullVec   (fullVec),
    .nonEmpty  (rxNotEmpty),
    .popAck    (popAck),
    .strobe    (strobe),
    .msgWord   (msgWord),
    .irq       (irq)
  );

  mbox_datapath #(.NUM_TGT(NUM_TGT), .DEPTH(DEPTH), .ID_W(ID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .msgWord  (msgWord),
    .popReq   (popReq),
    .rxSel    (rxSel),
    .fullVec  (fullVec),
    .nonEmpty (rxNotEmpty),
    .popAck   (popAck),
    .rxData   (rxData)
  );
endmodule

// File: rtl/mbox_inbox_chk.sv
module mbox_inbox_chk
  import mbox_pkg::*;
#(
  parameter int NUM_TGT = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                wrBit0,
  input logic [FIELD_W-1:0]  rdBusy,
  input logic [NUM_TGT-1:0]  popReq,
  input logic [NUM_TGT-1:0]  rxNotEmpty,
  input logic                irq,
  input logic                commit,
  input logic [MAX_ID_W-1:0] tgt,
  input logic [NUM_TGT-1:0]  fullVec
);
  AST_BUSY_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_STAT) |-> (rdBusy[NUM_TGT-1:0] == rxNotEmpty)); // R4

  AST_COMMIT_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !fullVec[tgt]) |=> rxNotEmpty[$past(tgt)]); // R3

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (commit && fullVec[tgt] && (popReq == '0)) |=> $stable(rxNotEmpty)); // R5

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    ((popReq != '0) && (rxNotEmpty == '0) && !commit) |=> (rxNotEmpty == '0)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(busWrEn && ((busAddr == OFF_PEND) || (busAddr == OFF_MASK)))) |=> irq); // R9

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == OFF_PEND) && wrBit0 && ((popReq & rxNotEmpty) == '0)) |=> !irq); // R8
endmodule

bind mbox_inbox mbox_inbox_chk #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .wrBit0     (busWrData[0]),
  .rdBusy     (busRdData[7:0]),
  .popReq     (popReq),
  .rxNotEmpty (rxNotEmpty),
  .irq        (irq),
  .commit     (strobe.commit),
  .tgt        (strobe.tgt),
  .fullVec    (fullVec)
);

// File: tb/mbox_inbox_tb.sv
`timescale 1ns/1ps
module mbox_inbox_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  popReq = '0;
  logic [2:0]  rxSel = '0;
  logic [63:0] rxData;
  logic [7:0]  rxNotEmpty;
  logic        irq;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_inbox u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .popReq(popReq),
    .rxSel(rxSel), .rxData(rxData), .rxNotEmpty(rxNotEmpty), .irq(irq)
  );

  // behavioural reference model
  logic [63:0] mq [8][$];
  logic [7:0]  mTake, mLost;
  logic        mPend;
  logic [2:0]  mMask, mId;
  logic [31:0] mLo, mHi;

  function automatic logic [7:0] busyVec();
    logic [7:0] b;
    for (int t = 0; t < 8; t++) b[t] = (mq[t].size() != 0);
    return b;
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] a);
    case (a)
      5'h00: return {29'b0, mId};
      5'h04: return mLo;
      5'h08: return mHi;
      5'h14: return {8'h00, mTake, mLost, busyVec()};
      5'h18: return {31'b0, mPend};
      5'h1C: return {29'b0, mMask};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    for (int t = 0; t < 8; t++) mq[t].delete();
    mTake = '0; mLost = '0; mPend = 1'b0; mMask = 3'b111;
    mId = '0; mLo = '0; mHi = '0;
  endtask

  task automatic modelStep(input logic we, input logic [4:0] a,
                           input logic [31:0] d, input logic [7:0] pp);
    logic [7:0] fullPre, drop, dlv;
    drop = '0; dlv = '0;
    for (int t = 0; t < 8; t++) fullPre[t] = (mq[t].size() == 4);
    for (int t = 0; t < 8; t++) begin
      if (pp[t] && mq[t].size() > 0) begin
        void'(mq[t].pop_front());
        dlv[t] = 1'b1;
      end
    end
    if (we && a == 5'h0C && d[0]) begin
      if (fullPre[mId]) drop[mId] = 1'b1;
      else mq[mId].push_back({mHi, mLo});
    end
    if (we && a == 5'h10) begin
      mTake &= ~d[23:16];
      mLost &= ~d[15:8];
    end
    mTake |= dlv;
    mLost |= drop;
    mPend = (((|drop) && !mMask[1]) || ((|dlv) && !mMask[2])) ||
            (mPend && !(we && a == 5'h18 && d[0]));
    if (we) begin
      case (a)
        5'h00: mId = d[2:0];
        5'h04: mLo = d;
        5'h08: mHi = d;
        5'h1C: mMask = d[2:0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock with the given stimulus; outputs compared 1 ns after the edge
  task automatic tick(input logic we, input logic [4:0] a, input logic [31:0] d,
                      input logic [7:0] pp);
    busWrEn = we; busAddr = a; busWrData = d; popReq = pp;
    @(posedge clk);
    modelStep(we, a, d, pp);
    #1;
    busWrEn = 1'b0; popReq = '0;
    chk(irq == (mPend && !mMask[0]), "R9 irq line", {63'b0, irq},
        {63'b0, mPend && !mMask[0]});
    chk(rxNotEmpty == busyVec(), "R4 rxNotEmpty", {56'b0, rxNotEmpty},
        {56'b0, busyVec()});
    if (mq[rxSel].size() > 0)
      chk(rxData == mq[rxSel][0], "R10 head view", rxData, mq[rxSel][0]);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    busAddr = a;
    #1;
    chk(busRdData == expRead(a), tag, {32'b0, busRdData}, {32'b0, expRead(a)});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    tick(1'b1, a, d, 8'h00);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    rd(5'h14, "R1 status after reset");
    rd(5'h1C, "R1 mask after reset");
    rd(5'h18, "R1 pending after reset");
    chk(irq == 1'b0, "R1 irq after reset", {63'b0, irq}, 64'h0);
    chk(rxNotEmpty == 8'h00, "R1 queues after reset", {56'b0, rxNotEmpty}, 64'h0);

    // R2 staging registers
    wr(5'h04, 32'hA5A5_0001);
    wr(5'h08, 32'h5A5A_0001);
    wr(5'h00, 32'h0000_00FF);
    rd(5'h04, "R2 low word");
    rd(5'h08, "R2 high word");
    rd(5'h00, "R2 target index");
    chk(busRdData == 32'h7, "R2 index truncated", {32'b0, busRdData}, 64'h7);

    // R3 commit with bit0 clear does nothing
    wr(5'h0C, 32'h0000_0002);
    rd(5'h14, "R3 no commit");
    // R3 real commit to target 7
    rxSel = 3'd7;
    wr(5'h0C, 32'h1);
    rd(5'h14, "R4 busy bit 7");
    chk(rxData == 64'h5A5A0001_A5A50001, "R10 message to target 7", rxData,
        64'h5A5A0001_A5A50001);

    // R5 fill target 2 and overflow it
    rxSel = 3'd2;
    wr(5'h00, 32'h2);
    for (int k = 0; k < 5; k++) begin
      wr(5'h04, 32'h1000 + k);
      wr(5'h08, 32'hF000 + k);
      wr(5'h0C, 32'h1);
    end
    rd(5'h14, "R5 overflow flag target 2");
    chk(busRdData[10] == 1'b1, "R5 overflow bit 10", {63'b0, busRdData[10]}, 64'h1);

    // R8 unmask all, pop target 2 -> taken event
    wr(5'h1C, 32'h0);
    tick(1'b0, 5'h00, 32'h0, 8'h04);
    rd(5'h14, "R6 taken flag target 2");
    rd(5'h18, "R8 pending after take");
    chk(rxData == 64'h0000F001_00001001, "R3 queue order", rxData, 64'h0000F001_00001001);
    // R9 mask line
    wr(5'h1C, 32'h1);
    chk(irq == 1'b0, "R9 line masked", {63'b0, irq}, 64'h0);
    rd(5'h18, "R9 pending kept while masked");
    wr(5'h18, 32'h1);
    rd(5'h18, "R8 pending cleared");
    wr(5'h1C, 32'h0);
    // R6 pop on empty target
    tick(1'b0, 5'h00, 32'h0, 8'h20);
    rd(5'h14, "R6 empty pop no effect");
    rd(5'h18, "R8 no event from empty pop");
    // R7 clear racing a new take on target 2
    tick(1'b1, 5'h10, 32'h00FF_FF00, 8'h04);
    rd(5'h14, "R7 set wins over clear");
    // R7 partial clear
    tick(1'b0, 5'h00, 32'h0, 8'h80);
    wr(5'h10, 32'h0080_0000);
    rd(5'h14, "R7 partial clear");
    // R8 clear racing an event
    tick(1'b1, 5'h18, 32'h1, 8'h04);
    rd(5'h18, "R8 set wins over clear");
    // R5 full queue with pop in same cycle still drops
    wr(5'h00, 32'h2);
    while (mq[2].size() < 4) wr(5'h0C, 32'h1);
    wr(5'h10, 32'h0000_FF00);
    tick(1'b1, 5'h0C, 32'h1, 8'h04);
    rd(5'h14, "R5 drop despite pop");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [7:0]  pp;
      r = $urandom;
      pp = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rxSel = 3'($urandom);
      case (r[2:0])
        3'd0: tick(1'b1, 5'h04, $urandom, pp);
        3'd1: tick(1'b1, 5'h08, $urandom, pp);
        3'd2: tick(1'b1, 5'h00, $urandom, pp);
        3'd3, 3'd4: tick(1'b1, 5'h0C, {31'b0, r[8] | r[9]}, pp);
        3'd5: tick(1'b1, 5'h10, $urandom, pp);
        3'd6: tick(1'b1, 5'h18, {31'b0, r[10]}, pp);
        default: tick(r[11] & r[12], 5'h1C, {29'b0, r[15:13]}, pp);
      endcase
      if (r[20:18] == 3'd0) rd(5'h14, "R7 status during traffic");
      if (r[23:21] == 3'd0) rd(5'h18, "R8 pending during traffic");
    end

    // drain every queue
    for (int i = 0; i < 6; i++) tick(1'b0, 5'h00, 32'h0, 8'hFF);
    rd(5'h14, "R6 all drained");
    chk(rxNotEmpty == 8'h00, "R4 all empty", {56'b0, rxNotEmpty}, 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule